// File: doc/BRIEF.md
# System Clock Divider and Block Clock Gate

This unit sits in the main clock domain and turns that clock into a divided system clock enable plus one gated enable per downstream block. Software programs it through a small synchronous register port with four word slots: a pending main-clock-source choice, an update strobe that commits that choice, an 8-bit divide ratio, and a per-block enable mask. The committed source choice is a plain output that steers an external clock multiplexer.

The divided output is a one-cycle pulse, issued once every N main-clock cycles. A ratio of zero halts it. A new ratio is taken up only when the period in progress ends, so no period is ever cut short. Each block enable is the system pulse masked by that block's bit. The core-fabric bit can never be cleared.

Register slots, selected by `addr_i`: 0 = pending source (bits [1:0]), 1 = update strobe (bit 0), 2 = divide ratio (bits [7:0]), 3 = enable mask (bit 0 fabric, bit 1 ROM, bit 2 RAM). A write happens on the rising edge on which `wr_en_i` is high. `rdata_o` shows the slot chosen by `addr_i` in the same cycle.

Top module: `sysclk_ctrl`

## Requirements
- R1: With a divide ratio N in 1..255, `sys_en_o` pulses for one cycle every N cycles, so consecutive pulses are exactly N cycles apart. With N = 1 it is high every cycle.
- R2: With a divide ratio of 0, `sys_en_o` and every bit of `blk_en_o` stay low once the period in progress has ended.
- R3: After reset the ratio reads 1, the enable mask reads 3'b111, the update bit reads 0, the pending and committed sources are 0, and `sys_en_o` is high in every cycle.
- R4: Mask bit 0 (fabric) always reads 1 and ignores writes of 0. `blk_en_o[0]` equals `sys_en_o` in every cycle.
- R5: Mask bit 1 gates `blk_en_o[1]` (ROM) and mask bit 2 gates `blk_en_o[2]` (RAM). Writing 0 to a bit holds that output low. No block enable is ever high while `sys_en_o` is low.
- R6: A ratio written in the middle of a period does not shorten or lengthen that period. The period ends at the old length, and the new length applies from the following period on.
- R7: `src_o` copies the pending source only on a write that takes the update bit from 0 to 1. Writing 1 while the bit is already 1 has no effect, and neither does writing 0.
- R8: Bits outside the defined fields of all four slots read as 0, even after writes of all ones.
- R9: Writing the pending source alone leaves `src_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock (the selected source) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register slot select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected slot |
| src_o | output | 2 | Committed main-clock source choice |
| sys_en_o | output | 1 | Divided system clock enable pulse |
| blk_en_o | output | 3 | Gated enables: [0] fabric, [1] ROM, [2] RAM |

## Verification
The period property assumes that the ratio held inside the divider changes only at a period boundary or while stopped. It also treats the first pulse after reset, and the first pulse after a restart from zero, as unarmed, because no earlier pulse exists to measure from. The source-hold property assumes that writes arrive only through `wr_en_i` with a stable `addr_i`. The stimulus drives every input on the falling clock edge and holds the strobe for exactly one rising edge. It waits through the end of any period in progress before it measures a new pulse spacing.

// File: rtl/sysclk_ctrl_pkg.sv
package sysclk_ctrl_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned SRC_W  = 2;
  localparam int unsigned RATIO_W = 8;
  localparam int unsigned NBLK   = 3;

  typedef enum logic [ADDR_W-1:0] {
    SLOT_SRC   = 2'd0,
    SLOT_UPD   = 2'd1,
    SLOT_RATIO = 2'd2,
    SLOT_MASK  = 2'd3
  } slot_e;

  localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(1);
  localparam logic [NBLK-1:0]    MASK_RST  = '1;
endpackage

// File: rtl/sysclk_regs.sv
module sysclk_regs
  import sysclk_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [SRC_W-1:0]   src_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [NBLK-1:0]    mask_o
);
  logic [SRC_W-1:0]   pend_q, act_q;
  logic               upd_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [NBLK-1:1]    mask_q;
  logic               commit;
  logic               unused_wbits;

  assign unused_wbits = ^wdata_i;
  assign commit = wr_en_i && (slot_e'(addr_i) == SLOT_UPD) && wdata_i[0] && !upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      act_q   <= '0;
      upd_q   <= 1'b0;
      ratio_q <= RATIO_RST;
      mask_q  <= MASK_RST[NBLK-1:1];
    end else begin
      if (commit) act_q <= pend_q;
      if (wr_en_i) begin
        case (slot_e'(addr_i))
          SLOT_SRC:   pend_q  <= wdata_i[SRC_W-1:0];
          SLOT_UPD:   upd_q   <= wdata_i[0];
          SLOT_RATIO: ratio_q <= wdata_i[RATIO_W-1:0];
          SLOT_MASK:  mask_q  <= wdata_i[NBLK-1:1];
          default: ;
        endcase
      end
    end
  end

  assign mask_o  = {mask_q, 1'b1};
  assign src_o   = act_q;
  assign ratio_o = ratio_q;

  always_comb begin
    rdata_o = '0;
    case (slot_e'(addr_i))
      SLOT_SRC:   rdata_o[SRC_W-1:0]   = pend_q;
      SLOT_UPD:   rdata_o[0]           = upd_q;
      SLOT_RATIO: rdata_o[RATIO_W-1:0] = ratio_q;
      SLOT_MASK:  rdata_o[NBLK-1:0]    = mask_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
  import sysclk_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               tick_o
);
  logic [RATIO_W-1:0] cur_q;
  logic [RATIO_W-1:0] cnt_q;
  logic               running;

  assign running = (cur_q != '0);
  assign tick_o  = running && (cnt_q == cur_q - RATIO_W'(1));

  // New ratio is loaded only at a period boundary or while halted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= RATIO_RST;
      cnt_q <= '0;
    end else if (!running || tick_o) begin
      cur_q <= ratio_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + RATIO_W'(1);
    end
  end
endmodule

// File: rtl/sysclk_gate.sv
module sysclk_gate
  import sysclk_ctrl_pkg::*;
(
  input  logic            tick_i,
  input  logic [NBLK-1:0] mask_i,
  output logic [NBLK-1:0] en_o
);
  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    assign en_o[g] = tick_i & mask_i[g];
  end
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic [1:0]  src_o,
  output logic        sys_en_o,
  output logic [2:0]  blk_en_o
);
  logic [RATIO_W-1:0] ratio;
  logic [NBLK-1:0]    mask;

  sysclk_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .src_o(src_o),
    .ratio_o(ratio), .mask_o(mask)
  );

  sysclk_divider u_div (
    .clk(clk), .rst_n(rst_n), .ratio_i(ratio), .tick_o(sys_en_o)
  );

  sysclk_gate u_gate (
    .tick_i(sys_en_o), .mask_i(mask), .en_o(blk_en_o)
  );
endmodule

// File: rtl/sysclk_ctrl_sva.sv
module sysclk_ctrl_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en_i,
  input logic [1:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic [1:0]  src_o,
  input logic        sys_en_o,
  input logic [2:0]  blk_en_o,
  input logic [7:0]  cur_n,
  input logic        upd_q
);
  logic [7:0] gap_q;
  logic       armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (sys_en_o) gap_q <= '0;
      else if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
      if (cur_n == '0) armed_q <= 1'b0;
      else if (sys_en_o) armed_q <= 1'b1;
    end
  end

  p_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_en_o && armed_q) |-> (gap_q == 8'(cur_n - 8'd1)));

  p_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_n == '0) |-> (!sys_en_o && blk_en_o == '0));

  p_fabric_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_en_o[0] == sys_en_o);

  p_fabric_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == 2'd3) |-> rdata_o[0]);

  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_en_o |-> (blk_en_o == '0));

  p_src_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == 2'd1 && wdata_i[0] && !upd_q) |=> $stable(src_o));

  p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[31:8] == '0);
endmodule

bind sysclk_ctrl sysclk_ctrl_sva chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .src_o(src_o),
  .sys_en_o(sys_en_o), .blk_en_o(blk_en_o),
  .cur_n(u_div.cur_q), .upd_q(u_regs.upd_q)
);

// File: tb/sysclk_ctrl_tb_top.sv
`timescale 1ns/1ps
module sysclk_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  src;
  logic        sys_en;
  logic [2:0]  blk_en;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sysclk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_o(src),
    .sys_en_o(sys_en), .blk_en_o(blk_en)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // Advance to a negedge at which sys_en is high.
  task automatic wait_pulse();
    int k;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!sys_en && k < 2000);
  endtask

  task automatic gap(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!sys_en && g < 2000);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd2, d); check("R3 ratio", d, 32'd1);
    rd(2'd3, d); check("R3 mask", d, 32'd7);
    rd(2'd1, d); check("R3 upd", d, 32'd0);
    rd(2'd0, d); check("R3 pend src", d, 32'd0);
    check("R3 src", {30'd0, src}, 32'd0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R3 sys_en every cycle", {31'd0, sys_en}, 32'd1);
    end
  endtask

  task automatic t_ratio(int n);
    int g;
    wr(2'd2, n);
    wait_pulse();
    wait_pulse();
    gap(g);
    check($sformatf("R1 spacing N=%0d", n), g, n);
    gap(g);
    check($sformatf("R1 spacing again N=%0d", n), g, n);
  endtask

  task automatic t_halt();
    int g;
    int hi;
    wr(2'd2, 32'd0);
    repeat (300) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (sys_en || blk_en != 3'b000) hi++;
    end
    check("R2 halted outputs", hi, 0);
    wr(2'd2, 32'd5);
    wait_pulse();
    gap(g);
    check("R2 restart spacing", g, 5);
  endtask

  task automatic t_reprogram();
    int g;
    wr(2'd2, 32'd8);
    wait_pulse();
    wait_pulse();
    // Two negedges pass inside wr; period of 8 is in progress.
    wr(2'd2, 32'd2);
    gap(g);
    check("R6 old period completes", g + 2, 8);
    gap(g);
    check("R6 new period", g, 2);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    wr(2'd2, 32'd1);
    wait_pulse();
    wr(2'd3, 32'd0);
    rd(2'd3, d); check("R4 fabric bit sticks", d, 32'd1);
    @(negedge clk);
    check("R5 rom/ram gated", {29'd0, blk_en}, 32'd1);
    check("R4 fabric follows", {31'd0, blk_en[0]}, {31'd0, sys_en});
    wr(2'd3, 32'd2);
    @(negedge clk);
    check("R5 rom only", {29'd0, blk_en}, 32'd3);
    wr(2'd3, 32'd4);
    @(negedge clk);
    check("R5 ram only", {29'd0, blk_en}, 32'd5);
    wr(2'd2, 32'd3);
    wr(2'd3, 32'd7);
    wait_pulse();
    @(negedge clk);
    check("R5 low off pulse", {29'd0, blk_en}, 32'd0);
  endtask

  task automatic t_update();
    wr(2'd0, 32'd2);
    @(negedge clk);
    check("R9 pend write alone", {30'd0, src}, 32'd0);
    wr(2'd1, 32'd1);
    check("R7 commit on rise", {30'd0, src}, 32'd2);
    wr(2'd0, 32'd3);
    wr(2'd1, 32'd1);
    check("R7 repeat 1 ignored", {30'd0, src}, 32'd2);
    wr(2'd1, 32'd0);
    check("R7 write 0 ignored", {30'd0, src}, 32'd2);
    wr(2'd1, 32'd1);
    check("R7 second commit", {30'd0, src}, 32'd3);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); check("R8 src slot", d, 32'h3);
    wr(2'd1, 32'hFFFF_FFFE); rd(2'd1, d); check("R8 upd slot", d, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d); check("R8 ratio slot", d, 32'hFF);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, d); check("R8 mask slot", d, 32'h7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ratio(1);
    t_ratio(3);
    t_ratio(7);
    t_ratio(255);
    t_halt();
    t_reprogram();
    t_gate();
    t_update();
    t_reserved();
    t_ratio(4);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule